// File: doc/BRIEF.md
# Tag Check Fault Response Controller

This block decides what happens once a memory tag mismatch has been detected for an access. Each cycle it may receive a failure strobe together with the faulting virtual address, the exception level of the access, a flag saying whether the translation regime splits the address space into two ranges, and the current system control register. It takes a 2-bit response mode from that register and acts on it. The field it reads depends on the level: unprivileged accesses use one field and all other levels use another.

The block supports four responses:
- It can ignore the failure.
- It can raise a one-cycle synchronous data-abort request. The request carries the faulting address, the fault status code 0x11 and a privileged-origin flag.
- It can set a sticky bit in the asynchronous fault status register of the access's level.
- For the reserved mode, it can pulse a diagnostic flag.

Software clears or rewrites a level's status bits only through a register write port.

The controller is a four-state machine. The states are ST_IDLE, ST_SYNC, ST_ASYNC and ST_RSVD. A strobe in any state moves the machine to the state that matches the decoded mode, and the mode value 0 leads to ST_IDLE. Without a strobe, every state returns to ST_IDLE. ST_SYNC drives the abort request. ST_ASYNC sets a status bit at the following edge. ST_RSVD drives the diagnostic flag.

Top module: `tcf_fault_resp`

## Requirements
- R1: After reset, `abort_valid`, `rsvd_flag`, `abort_fsc` and `abort_from_priv` are 0, and every bit of `fault_status` is 0.
- R2: The mode comes from `ctrl_reg[39:38]` when `fail_el` is 0, and from `ctrl_reg[41:40]` for any other level. The encodings are 0 = ignore, 1 = synchronous, 2 = asynchronous and 3 = reserved.
- R3: In mode 1, a strobe sampled at one clock edge produces `abort_valid` high for exactly the following cycle. In that cycle `abort_addr` equals the strobed address and `abort_fsc` is 0x11.
- R4: While `abort_valid` is high, `abort_from_priv` is 1 if and only if the strobed level was not 0.
- R5: In mode 0, a strobe raises neither `abort_valid` nor `rsvd_flag` and changes no status bit.
- R6: In mode 2 with `two_ranges` set, the strobe sets bit `fail_addr[55]` of the level's status field. Level L occupies `fault_status[2L+1:2L]`. The bit becomes visible after the second clock edge following the strobe.
- R7: In mode 2 with `two_ranges` clear, bit 0 of the level's field is set, whatever the value of address bit 55.
- R8: Status bits are sticky. Only a write through the port clears them, and further faults OR new bits into a field.
- R9: In mode 3, `rsvd_flag` is high for the cycle after the strobe, no abort is raised and no status changes.
- R10: A write replaces the selected level's field with `wr_data`. If an asynchronous set hits the same level at the same edge, the set bit is ORed over the written value.
- R11: Strobes in consecutive cycles are each handled with their own address and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_vld | input | 1 | Tag check failure strobe |
| fail_addr | input | ADDR_W | Faulting virtual address |
| fail_el | input | EL_W | Exception level of the access |
| two_ranges | input | 1 | Translation regime has two address ranges |
| ctrl_reg | input | CTRL_W | System control register value |
| wr_en | input | 1 | Status register write strobe |
| wr_el | input | EL_W | Level whose status field is written |
| wr_data | input | STICKY_W | Value written to the status field |
| abort_valid | output | 1 | Synchronous abort request pulse |
| abort_addr | output | ADDR_W | Faulting address for the abort |
| abort_fsc | output | FSC_W | Fault status code (0x11 while aborting) |
| abort_from_priv | output | 1 | Abort came from a level other than 0 |
| rsvd_flag | output | 1 | Reserved mode diagnostic pulse |
| fault_status | output | NUM_EL*STICKY_W | Per-level sticky asynchronous status bits |

## Verification
The bench builds the block with its default parameters: 64-bit addresses and control register, four levels, select bit 55, and mode fields at bits 38 and 40. Because of these defaults, the real bit-55 range selection and both mode fields are reachable. Random control words, levels and addresses cover every mode on every level. Directed sequences cover back-to-back strobes, the edge where a write and a set collide, and the reserved and ignore modes, with the status fields read back through the port.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_ASYNC = 2'd2,
        MODE_RSVD  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ASYNC,
        ST_RSVD
    } state_e;
endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel
    import tcf_pkg::*;
#(
    parameter int CTRL_W  = 64,
    parameter int EL_W    = 2,
    parameter int LO_USER = 38,
    parameter int LO_PRIV = 40
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [EL_W-1:0]   el,
    output mode_e             mode
);
    logic [1:0] user_f, priv_f;

    assign user_f = ctrl[LO_USER +: 2];
    assign priv_f = ctrl[LO_PRIV +: 2];

    always_comb begin
        if (el == '0) mode = mode_e'(user_f);
        else          mode = mode_e'(priv_f);
    end
endmodule

// File: rtl/tcf_status_bank.sv
module tcf_status_bank #(
    parameter int NUM_EL   = 4,
    parameter int EL_W     = 2,
    parameter int STICKY_W = 2,
    localparam int IDX_W   = (STICKY_W > 1) ? $clog2(STICKY_W) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [EL_W-1:0]              wr_el,
    input  logic [STICKY_W-1:0]          wr_data,
    input  logic                         set_en,
    input  logic [EL_W-1:0]              set_el,
    input  logic [IDX_W-1:0]             set_idx,
    output logic [NUM_EL*STICKY_W-1:0]   status
);
    for (genvar g = 0; g < NUM_EL; g++) begin : g_lvl
        logic [STICKY_W-1:0] bits_q, base, set_mask;

        always_comb begin
            base     = (wr_en && wr_el == EL_W'(g)) ? wr_data : bits_q;
            set_mask = '0;
            if (set_en && set_el == EL_W'(g)) set_mask[set_idx] = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bits_q <= '0;
            else        bits_q <= base | set_mask;
        end

        assign status[g*STICKY_W +: STICKY_W] = bits_q;
    end
endmodule

// File: rtl/tcf_fault_resp.sv
module tcf_fault_resp
    import tcf_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int CTRL_W   = 64,
    parameter int EL_W     = 2,
    parameter int STICKY_W = 2,
    parameter int SEL_BIT  = 55,
    parameter int LO_USER  = 38,
    parameter int LO_PRIV  = 40,
    parameter int FSC_W    = 6,
    parameter logic [FSC_W-1:0] FSC = 6'h11,
    localparam int NUM_EL  = 1 << EL_W,
    localparam int IDX_W   = (STICKY_W > 1) ? $clog2(STICKY_W) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fail_vld,
    input  logic [ADDR_W-1:0]          fail_addr,
    input  logic [EL_W-1:0]            fail_el,
    input  logic                       two_ranges,
    input  logic [CTRL_W-1:0]          ctrl_reg,
    input  logic                       wr_en,
    input  logic [EL_W-1:0]            wr_el,
    input  logic [STICKY_W-1:0]        wr_data,
    output logic                       abort_valid,
    output logic [ADDR_W-1:0]          abort_addr,
    output logic [FSC_W-1:0]           abort_fsc,
    output logic                       abort_from_priv,
    output logic                       rsvd_flag,
    output logic [NUM_EL*STICKY_W-1:0] fault_status
);
    state_e            state_q, state_d;
    mode_e             mode;
    logic [ADDR_W-1:0] addr_q;
    logic [EL_W-1:0]   el_q;
    logic [IDX_W-1:0]  idx_q;
    logic              set_en;

    tcf_mode_sel #(
        .CTRL_W(CTRL_W), .EL_W(EL_W), .LO_USER(LO_USER), .LO_PRIV(LO_PRIV)
    ) u_mode (
        .ctrl(ctrl_reg), .el(fail_el), .mode(mode)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (fail_vld) begin
            unique case (mode)
                MODE_OFF:   state_d = ST_IDLE;
                MODE_SYNC:  state_d = ST_SYNC;
                MODE_ASYNC: state_d = ST_ASYNC;
                MODE_RSVD:  state_d = ST_RSVD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            el_q    <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fail_vld) begin
                addr_q <= fail_addr;
                el_q   <= fail_el;
                idx_q  <= two_ranges ? IDX_W'(fail_addr[SEL_BIT]) : '0;
            end
        end
    end

    always_comb begin
        abort_valid     = 1'b0;
        abort_fsc       = '0;
        abort_from_priv = 1'b0;
        rsvd_flag       = 1'b0;
        set_en          = 1'b0;
        abort_addr      = addr_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_SYNC: begin
                abort_valid     = 1'b1;
                abort_fsc       = FSC;
                abort_from_priv = (el_q != '0);
            end
            ST_ASYNC: set_en    = 1'b1;
            ST_RSVD:  rsvd_flag = 1'b1;
        endcase
    end

    tcf_status_bank #(
        .NUM_EL(NUM_EL), .EL_W(EL_W), .STICKY_W(STICKY_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_el(wr_el), .wr_data(wr_data),
        .set_en(set_en), .set_el(el_q), .set_idx(idx_q),
        .status(fault_status)
    );
endmodule

// File: rtl/tcf_fault_chk.sv
module tcf_fault_chk #(
    parameter int ADDR_W   = 64,
    parameter int CTRL_W   = 64,
    parameter int EL_W     = 2,
    parameter int STICKY_W = 2,
    parameter int LO_USER  = 38,
    parameter int LO_PRIV  = 40,
    parameter int FSC_W    = 6,
    parameter logic [FSC_W-1:0] FSC = 6'h11,
    localparam int NUM_EL  = 1 << EL_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       fail_vld,
    input logic [ADDR_W-1:0]          fail_addr,
    input logic [EL_W-1:0]            fail_el,
    input logic [CTRL_W-1:0]          ctrl_reg,
    input logic                       wr_en,
    input logic                       abort_valid,
    input logic [ADDR_W-1:0]          abort_addr,
    input logic [FSC_W-1:0]           abort_fsc,
    input logic                       rsvd_flag,
    input logic [NUM_EL*STICKY_W-1:0] fault_status
);
    logic [1:0] req_mode;
    assign req_mode = (fail_el == '0) ? ctrl_reg[LO_USER +: 2] : ctrl_reg[LO_PRIV +: 2];

    assert_abort_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> abort_fsc == FSC);

    assert_abort_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> ($past(fail_vld) && abort_addr == $past(fail_addr)));

    assert_sync_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && req_mode == 2'd1) |=> abort_valid);

    assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_vld && req_mode == 2'd0) |=> (!abort_valid && !rsvd_flag));

    assert_rsvd_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_flag |-> !abort_valid);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ((fault_status & $past(fault_status)) == $past(fault_status)));
endmodule

bind tcf_fault_resp tcf_fault_chk #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .EL_W(EL_W), .STICKY_W(STICKY_W),
    .LO_USER(LO_USER), .LO_PRIV(LO_PRIV), .FSC_W(FSC_W), .FSC(FSC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fail_vld(fail_vld), .fail_addr(fail_addr),
    .fail_el(fail_el), .ctrl_reg(ctrl_reg), .wr_en(wr_en),
    .abort_valid(abort_valid), .abort_addr(abort_addr), .abort_fsc(abort_fsc),
    .rsvd_flag(rsvd_flag), .fault_status(fault_status)
);

// File: tb/sim_tcf_fault_resp.sv
module sim_tcf_fault_resp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fail_vld = 1'b0;
    logic [63:0] fail_addr = '0;
    logic [1:0]  fail_el = '0;
    logic        two_ranges = 1'b0;
    logic [63:0] ctrl_reg = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_el = '0;
    logic [1:0]  wr_data = '0;
    logic        abort_valid, abort_from_priv, rsvd_flag;
    logic [63:0] abort_addr;
    logic [5:0]  abort_fsc;
    logic [7:0]  fault_status;

    int errors = 0;
    int checks = 0;
    logic [7:0] model = '0;

    always #5 clk = ~clk;

    tcf_fault_resp u0 (
        .clk(clk), .rst_n(rst_n), .fail_vld(fail_vld), .fail_addr(fail_addr),
        .fail_el(fail_el), .two_ranges(two_ranges), .ctrl_reg(ctrl_reg),
        .wr_en(wr_en), .wr_el(wr_el), .wr_data(wr_data),
        .abort_valid(abort_valid), .abort_addr(abort_addr), .abort_fsc(abort_fsc),
        .abort_from_priv(abort_from_priv), .rsvd_flag(rsvd_flag),
        .fault_status(fault_status)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input logic [63:0] c, input logic [1:0] el);
        return (el == 2'd0) ? c[39:38] : c[41:40];
    endfunction

    function automatic logic [63:0] ctrl_for(input logic [1:0] el, input logic [1:0] m, input logic [63:0] base);
        logic [63:0] c = base;
        if (el == 2'd0) c[39:38] = m; else c[41:40] = m;
        return c;
    endfunction

    // One strobe: drive at negedge, check pulse after the next edge, status after the one after.
    task automatic one_fault(input logic [63:0] a, input logic [1:0] el, input bit tr, input logic [63:0] c, input string tag);
        logic [1:0] m = exp_mode(c, el);
        fail_vld = 1'b1; fail_addr = a; fail_el = el; two_ranges = tr; ctrl_reg = c;
        @(negedge clk);
        fail_vld = 1'b0;
        chk(abort_valid == (m == 2'd1), {tag, " R3 abort_valid"}, 64'(abort_valid), 64'(m == 2'd1));
        if (m == 2'd1) begin
            chk(abort_addr == a, {tag, " R3 abort_addr"}, abort_addr, a);
            chk(abort_fsc == 6'h11, {tag, " R3 fsc"}, 64'(abort_fsc), 64'h11);
            chk(abort_from_priv == (el != 2'd0), {tag, " R4 priv"}, 64'(abort_from_priv), 64'(el != 2'd0));
        end
        chk(rsvd_flag == (m == 2'd3), {tag, " R9 rsvd_flag"}, 64'(rsvd_flag), 64'(m == 2'd3));
        if (m == 2'd2) model[el*2 + (tr ? 32'(a[55]) : 0)] = 1'b1;
        @(negedge clk);
        chk(abort_valid == 1'b0, {tag, " R3 pulse width"}, 64'(abort_valid), 64'd0);
        chk(fault_status == model, {tag, m == 2'd2 ? (tr ? " R6 status" : " R7 status") : " R5 status"},
            64'(fault_status), 64'(model));
    endtask

    task automatic do_write(input logic [1:0] el, input logic [1:0] d);
        wr_en = 1'b1; wr_el = el; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[el*2 +: 2] = d;
        chk(fault_status == model, "R10 write", 64'(fault_status), 64'(model));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(abort_valid == 0 && rsvd_flag == 0 && abort_fsc == 0 && abort_from_priv == 0,
            "R1 outputs in reset", 64'({abort_valid, rsvd_flag, abort_fsc}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_status == 8'd0, "R1 status after reset", 64'(fault_status), 64'd0);

        // R2: EL0 field vs privileged field distinguished
        one_fault(64'h0000_1000, 2'd0, 1'b0, 64'h0000_0100_0000_0000 | (64'd1 << 38), "R2 user field");
        one_fault(64'h0000_2000, 2'd1, 1'b0, (64'd1 << 38), "R2 priv ignores user field");
        one_fault(64'h0000_3000, 2'd2, 1'b0, (64'd1 << 40), "R2 priv field");
        // R6 / R7 bit 55 selection
        one_fault(64'h0080_0000_0000_0000, 2'd3, 1'b1, ctrl_for(2'd3, 2'd2, 0), "R6 bit55=1");
        one_fault(64'h0080_0000_0000_0000, 2'd1, 1'b0, ctrl_for(2'd1, 2'd2, 0), "R7 single range");
        // R8 accumulate
        one_fault(64'h0, 2'd3, 1'b1, ctrl_for(2'd3, 2'd2, 0), "R8 accumulate");
        chk(fault_status[7:6] == 2'b11, "R8 both bits held", 64'(fault_status[7:6]), 64'd3);
        // R9 reserved and R5 off
        one_fault(64'hdead, 2'd2, 1'b1, ctrl_for(2'd2, 2'd3, 0), "R9 reserved");
        one_fault(64'hbeef, 2'd0, 1'b1, ctrl_for(2'd0, 2'd0, 0), "R5 off");

        // R10 collision: set and write on the same edge
        fail_vld = 1'b1; fail_addr = 64'h0080_0000_0000_0000; fail_el = 2'd2; two_ranges = 1'b1;
        ctrl_reg = ctrl_for(2'd2, 2'd2, 0);
        @(negedge clk);
        fail_vld = 1'b0;
        wr_en = 1'b1; wr_el = 2'd2; wr_data = 2'b00;
        @(negedge clk);
        wr_en = 1'b0;
        model[5:4] = 2'b10;
        chk(fault_status == model, "R10 set over write", 64'(fault_status), 64'(model));

        // R11 back-to-back sync strobes
        fail_vld = 1'b1; fail_el = 2'd1; ctrl_reg = ctrl_for(2'd1, 2'd1, 0); fail_addr = 64'hA0;
        @(negedge clk);
        chk(abort_valid && abort_addr == 64'hA0, "R11 first", abort_addr, 64'hA0);
        fail_addr = 64'hB0; fail_el = 2'd0; ctrl_reg = ctrl_for(2'd0, 2'd1, 0);
        @(negedge clk);
        fail_vld = 1'b0;
        chk(abort_valid && abort_addr == 64'hB0, "R11 second", abort_addr, 64'hB0);
        chk(abort_from_priv == 1'b0, "R11 R4 second priv", 64'(abort_from_priv), 64'd0);
        @(negedge clk);

        for (int el = 0; el < 4; el++) do_write(2'(el), 2'b00);

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                do_write(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
            else
                one_fault({$urandom, $urandom}, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                          {$urandom, $urandom}, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule